// File: doc/BRIEF.md
# Sustained Silence Mute Detector

This block watches the decoded audio words that a serial receiver hands over once per frame, with one left and one right word for each stereo pair. It flags a pair as silent once both of that pair's words have been exactly zero for a run of consecutive frames. That run stands for roughly half a second of audio. The length is counted in frames and not in clock cycles, so the window follows the sample rate. A rate selector picks a threshold of half the frame rate: 16000, 22050, 24000 or 48000 frames. The per-pair flags drive the downstream mute action. A global flag goes high only when every pair is silent.

Two separate controls gate detection, and either one can turn it off. The first is an active-low automute bit in the main control register. When it is 0, detection runs. When it is 1, detection is off. The second is a disable bit in the test register. When it is 1, detection is off. After reset both controls sit at 0, so detection is on. While detection is off, every flag is low and every frame count is cleared. The parameter `THR_SHIFT` divides the threshold by a power of two, which lets a bench reach the mute point quickly.

Each pair runs a three-state machine:
- **OFF**: detection is disabled.
- **LISTEN**: counting zero frames.
- **SILENT**: muted.

The transitions are:
- **disable**: any state goes to OFF when detection is off.
- **arm**: OFF goes to LISTEN when detection is on.
- **reach**: LISTEN goes to SILENT on the zero frame that brings the count to the threshold.
- **break**: LISTEN or SILENT goes to LISTEN with the count at zero on a frame that carries a nonzero word.
- **keep**: SILENT stays in SILENT on further zero frames.

When detection is already on, a frame that arrives in OFF is handled exactly as it would be in LISTEN.

Top module: `zmute_detector`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every `pair_mute` bit and `all_mute` are 0.
- R2: A pair's mute bit goes to 1 in the cycle after the strobe of the N-th consecutive frame in which both of its words are zero, where N is the current threshold. Before that strobe it stays 0.
- R3: A strobed frame with any nonzero word in a pair clears that pair's count and drops its mute bit in the following cycle. The next mute needs a full new run of N zero frames.
- R4: Cycles in which `frame_stb` is 0 neither advance nor clear any count, whatever is on `samples`.
- R5: `rate_sel` selects N as the base value shifted right by `THR_SHIFT`, with a minimum of 1. The base values are 0 → 16000, 1 → 22050, 2 → 24000 and 3 → 48000.
- R6: While `automute_off` is 1, all mute outputs are 0 and all counts are cleared. After it returns to 0, a pair needs N fresh zero frames to mute.
- R7: While `test_disable` is 1, all mute outputs are 0 and all counts are cleared, with the same restart behaviour as R6.
- R8: Once a pair is muted, further zero frames keep it muted indefinitely. The count saturates and does not wrap.
- R9: The pairs count independently. `all_mute` is 1 exactly when every pair's mute bit is 1.
- R10: A word counts as zero only when all `SAMPLE_W` bits are 0. Pair p's left word is `samples[2p*SAMPLE_W +: SAMPLE_W]` and its right word is `samples[(2p+1)*SAMPLE_W +: SAMPLE_W]`. A single set LSB in either word breaks the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe: `samples` holds a new frame |
| samples | input | NUM_PAIRS*2*SAMPLE_W | Frame words, packed by pair, left word then right word |
| automute_off | input | 1 | Active-low automute enable bit (1 turns detection off) |
| test_disable | input | 1 | Test-register disable bit (1 turns detection off) |
| rate_sel | input | 2 | Sample-rate code that picks the frame threshold |
| pair_mute | output | NUM_PAIRS | Per-pair silence flag |
| all_mute | output | 1 | High when every pair is silent |

## Verification
The bench first targets the exact threshold edge. A detector with an off-by-one count would mute one frame early or one frame late, and the bench samples the flag on both sides of the N-th strobe. It sends nonzero words made of a single LSB in a right-hand word, and makes a run break midway through a count. Together these catch a zero test that looks at only part of a word, and a count that is held instead of cleared. The bench also sends long zero runs after the mute point, which expose a counter that wraps and silently unmutes. It toggles both disable controls in the middle of a run and re-enables detection to check that counting restarts from zero. It fills the idle cycles between strobes with nonzero garbage, which catches logic that samples the bus without the strobe.

// File: rtl/zmute_pkg.sv
`timescale 1ns/1ps
package zmute_pkg;

    typedef enum logic [1:0] {
        ZM_OFF    = 2'd0,
        ZM_LISTEN = 2'd1,
        ZM_SILENT = 2'd2
    } zm_state_e;

    localparam int unsigned HALF_FS_32K  = 16000;
    localparam int unsigned HALF_FS_44K  = 22050;
    localparam int unsigned HALF_FS_48K  = 24000;
    localparam int unsigned HALF_FS_96K  = 48000;
    localparam int unsigned MAX_THR      = HALF_FS_96K;
    localparam int          CNT_W        = $clog2(MAX_THR + 1);

endpackage

// File: rtl/zmute_thresh.sv
`timescale 1ns/1ps
module zmute_thresh
    import zmute_pkg::*;
#(
    parameter int THR_SHIFT = 0
) (
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] thr_o
);

    int unsigned base;
    int unsigned scaled;

    always_comb begin
        unique case (rate_sel)
            2'd0:    base = HALF_FS_32K;
            2'd1:    base = HALF_FS_44K;
            2'd2:    base = HALF_FS_48K;
            default: base = HALF_FS_96K;
        endcase
        scaled = base >> THR_SHIFT;
        if (scaled == 0) begin
            scaled = 1;
        end
        thr_o = scaled[CNT_W-1:0];
    end

endmodule

// File: rtl/zmute_pair_zero.sv
`timescale 1ns/1ps
module zmute_pair_zero #(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                both_zero_o
);

    always_comb begin
        both_zero_o = ~(|left_i) & ~(|right_i);
    end

endmodule

// File: rtl/zmute_pair_fsm.sv
`timescale 1ns/1ps
module zmute_pair_fsm
    import zmute_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             frame_stb,
    input  logic             pair_zero,
    input  logic [CNT_W-1:0] thr,
    output logic             mute_o
);

    zm_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!det_en) begin
            state_d = ZM_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ZM_OFF, ZM_LISTEN: begin
                    if (frame_stb) begin
                        if (pair_zero) begin
                            if (cnt_inc >= {1'b0, thr}) begin
                                state_d = ZM_SILENT;
                                cnt_d   = thr;
                            end else begin
                                state_d = ZM_LISTEN;
                                cnt_d   = cnt_inc[CNT_W-1:0];
                            end
                        end else begin
                            state_d = ZM_LISTEN;
                            cnt_d   = '0;
                        end
                    end else begin
                        state_d = ZM_LISTEN;
                    end
                end
                ZM_SILENT: begin
                    if (frame_stb && !pair_zero) begin
                        state_d = ZM_LISTEN;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ZM_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZM_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        mute_o = (state_q == ZM_SILENT);
    end

    AST_NONZERO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && frame_stb && !pair_zero) |=> !mute_o); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> (!mute_o && cnt_q == '0)); // R6
    AST_RISE_ON_ZERO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_o) |-> $past(frame_stb && pair_zero)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_THR)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && !frame_stb) |=> $stable(mute_o)); // R4

endmodule

// File: rtl/zmute_detector.sv
`timescale 1ns/1ps
module zmute_detector
    import zmute_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int SAMPLE_W  = 24,
    parameter int THR_SHIFT = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_stb,
    input  logic [NUM_PAIRS*2*SAMPLE_W-1:0] samples,
    input  logic                            automute_off,
    input  logic                            test_disable,
    input  logic [1:0]                      rate_sel,
    output logic [NUM_PAIRS-1:0]            pair_mute,
    output logic                            all_mute
);

    logic             det_en;
    logic [CNT_W-1:0] thr;

    always_comb begin
        det_en = ~automute_off & ~test_disable;
    end

    zmute_thresh #(
        .THR_SHIFT (THR_SHIFT)
    ) u_thresh (
        .rate_sel (rate_sel),
        .thr_o    (thr)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic both_zero;

        zmute_pair_zero #(
            .SAMPLE_W (SAMPLE_W)
        ) u_zero (
            .left_i      (samples[(2*p)*SAMPLE_W +: SAMPLE_W]),
            .right_i     (samples[(2*p+1)*SAMPLE_W +: SAMPLE_W]),
            .both_zero_o (both_zero)
        );

        zmute_pair_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .det_en    (det_en),
            .frame_stb (frame_stb),
            .pair_zero (both_zero),
            .thr       (thr),
            .mute_o    (pair_mute[p])
        );
    end

    always_comb begin
        all_mute = &pair_mute;
    end

    AST_GLOBAL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_mute) |-> $past(frame_stb)); // R9
    AST_TEST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        test_disable |=> (pair_mute == '0 && !all_mute)); // R7

endmodule

// File: tb/zmute_detector_tb.sv
`timescale 1ns/1ps
module zmute_detector_tb;

    localparam int NP = 3;
    localparam int W  = 24;
    localparam int SH = 10;
    localparam int VW = NP * 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0;
    logic          am_off = 1'b0;
    logic          tdis = 1'b0;
    logic [1:0]    rate = 2'd0;
    logic [VW-1:0] smp = '0;
    wire  [NP-1:0] pm;
    wire           am;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";
    int    m_cnt[NP];
    bit    m_mute[NP];

    always #4 clk = ~clk;

    zmute_detector #(
        .NUM_PAIRS (NP),
        .SAMPLE_W  (W),
        .THR_SHIFT (SH)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_stb    (stb),
        .samples      (smp),
        .automute_off (am_off),
        .test_disable (tdis),
        .rate_sel     (rate),
        .pair_mute    (pm),
        .all_mute     (am)
    );

    function automatic int thr_of(logic [1:0] r);
        int b;
        case (r)
            2'd0:    b = 16000;
            2'd1:    b = 22050;
            2'd2:    b = 24000;
            default: b = 48000;
        endcase
        b = b >> SH;
        if (b < 1) b = 1;
        return b;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        bit en;
        bit z;
        en = !am_off && !tdis;
        for (int p = 0; p < NP; p++) begin
            if (!en) begin
                m_cnt[p]  = 0;
                m_mute[p] = 1'b0;
            end else if (stb) begin
                z = (smp[(2*p)*W +: W] == '0) && (smp[(2*p+1)*W +: W] == '0);
                if (!z) begin
                    m_cnt[p]  = 0;
                    m_mute[p] = 1'b0;
                end else if (!m_mute[p]) begin
                    if (m_cnt[p] + 1 >= thr_of(rate)) begin
                        m_mute[p] = 1'b1;
                        m_cnt[p]  = thr_of(rate);
                    end else begin
                        m_cnt[p] = m_cnt[p] + 1;
                    end
                end
            end
        end
    endtask

    task automatic tick();
        int exp_all;
        model_step();
        @(posedge clk);
        @(negedge clk);
        exp_all = 1;
        for (int p = 0; p < NP; p++) begin
            chk({tag, " pair flag vs model"}, int'(pm[p]), int'(m_mute[p]));
            if (!m_mute[p]) exp_all = 0;
        end
        chk({tag, " R9 global flag vs model"}, int'(am), exp_all);
    endtask

    task automatic send(input logic [VW-1:0] v, input int gap);
        smp = v;
        stb = 1'b1;
        tick();
        stb = 1'b0;
        for (int g = 0; g < gap; g++) begin
            smp = {VW{1'b1}};
            tick();
        end
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_cnt[p]  = 0;
            m_mute[p] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", int'(pm), 0);
        chk("R1 global in reset", int'(am), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 flags after release", int'(pm), 0);

        // R2: threshold 15 at rate 0, garbage between strobes (R4)
        tag = "R2";
        for (int i = 0; i < 14; i++) send('0, 1);
        chk("R2 one frame before threshold", int'(pm), 0);
        send('0, 2);
        chk("R2 at threshold", int'(pm), 7);
        chk("R9 global high when all silent", int'(am), 1);
        tag = "R4";
        for (int i = 0; i < 5; i++) begin
            smp = {VW{1'b1}};
            tick();
        end
        chk("R4 unstrobed garbage ignored", int'(pm), 7);

        // R8: saturation, no wrap
        tag = "R8";
        for (int i = 0; i < 60; i++) send('0, 0);
        chk("R8 stays muted after long run", int'(pm), 7);

        // R10 / R3: single LSB in pair 1 right word
        tag = "R10";
        send(VW'(1) << (3 * W), 0);
        chk("R10 LSB in right word breaks run", int'(pm), 5);
        chk("R9 global low when one pair active", int'(am), 0);
        tag = "R3";
        for (int i = 0; i < 14; i++) send('0, 0);
        chk("R3 count restarted", int'(pm), 5);
        send('0, 0);
        chk("R3 remute after full run", int'(pm), 7);
        send(VW'(1) << (W - 1), 0);
        chk("R3 pair0 MSB drops pair0", int'(pm), 6);
        for (int i = 0; i < 10; i++) send('0, 0);
        send(VW'(1) << W, 0);
        for (int i = 0; i < 14; i++) send('0, 0);
        chk("R3 mid-run break clears count", int'(pm), 6);
        send('0, 0);
        chk("R3 pair0 mutes after fresh run", int'(pm), 7);

        // R6: automute off
        tag = "R6";
        for (int i = 0; i < 7; i++) send('0, 0);
        am_off = 1'b1;
        tick();
        chk("R6 flags low when automute off", int'(pm), 0);
        for (int i = 0; i < 20; i++) send('0, 0);
        chk("R6 zero frames ignored while off", int'(pm), 0);
        am_off = 1'b0;
        for (int i = 0; i < 14; i++) send('0, 0);
        chk("R6 count cleared while off", int'(pm), 0);
        send('0, 0);
        chk("R6 mutes after fresh run", int'(pm), 7);

        // R7: test disable
        tag = "R7";
        tdis = 1'b1;
        tick();
        chk("R7 flags low when test disable", int'(pm), 0);
        for (int i = 0; i < 20; i++) send('0, 1);
        chk("R7 zero frames ignored while disabled", int'(pm), 0);
        tdis = 1'b0;
        for (int i = 0; i < 14; i++) send('0, 0);
        chk("R7 count cleared while disabled", int'(pm), 0);
        send('0, 0);
        chk("R7 mutes after fresh run", int'(pm), 7);

        // R5: each rate code
        tag = "R5";
        for (int r = 0; r < 4; r++) begin
            rate = 2'(r);
            tdis = 1'b1;
            tick();
            tdis = 1'b0;
            for (int i = 0; i < thr_of(2'(r)) - 1; i++) send('0, 0);
            chk($sformatf("R5 rate %0d below threshold", r), int'(pm), 0);
            send('0, 0);
            chk($sformatf("R5 rate %0d at threshold", r), int'(pm), 7);
        end

        // R9: independent pairs under mixed traffic
        tag = "R9";
        rate = 2'd0;
        for (int i = 0; i < 1500; i++) begin
            logic [VW-1:0] v;
            v = '0;
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(10 * (p + 1), 0) == 0) begin
                    v[(2 * p + $urandom_range(1, 0)) * W + $urandom_range(W - 1, 0)] = 1'b1;
                end
            end
            if ($urandom_range(400, 0) == 0) am_off = ~am_off;
            if (am_off && $urandom_range(8, 0) == 0) am_off = 1'b0;
            send(v, $urandom_range(2, 0));
        end
        am_off = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule